// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block provides two independent down-counting interval timers. Software reaches them through a word-aligned, memory-mapped register window. Each timer has three registers: a reload value, a live count and a control word. The control word turns the timer on, chooses between one-shot and periodic operation, and selects one of four counting rates. These rates are derived from a single free-running prescaler that both timers share. Each timer has its own interrupt request line, which pulses when the count runs out.

Every register write carries a privilege flag. A write issued in user mode changes nothing, and the block raises a protection fault output on the next cycle so that surrounding logic can handle the fault. Reads are combinational from the address bus.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of both timers reads 0, and all interrupt lines and the fault output are low.
- R2: Timer t occupies byte addresses 16*t to 16*t+15. Offset 0 is the reload register, offset 4 is the count register, offset 8 is the control register, and offset 12 reads 0 and ignores writes. An address whose two low bits are not 0 ignores writes and reads 0.
- R3: Control bit 0 is enable, bit 1 selects auto-reload, and bits 3:2 hold a rate code d that gives divide-by 2^d. A shared prescaler counts up every cycle from reset. An enabled timer takes a step on each clock edge where the low d bits of the prescaler are all 1. A disabled timer holds its count.
- R4: A step decrements the count by 1. A step taken at count 1 raises that timer's interrupt line for exactly the one cycle after that edge.
- R5: Single-shot mode: the step at count 1 leaves the count at 0 and clears enable. A step at count 0 clears enable and raises no interrupt.
- R6: Auto-reload mode: the step at count 1 loads the reload value and keeps enable set. A step at count 0 loads the reload value and raises no interrupt.
- R7: A user-mode write changes no register. The fault output is high for the one cycle after each user-mode write, whatever its address. A supervisor write never raises the fault.
- R8: A supervisor write to the count register of an enabled timer is held. The next step of that timer loads the held value in place of a decrement. If the timer is disabled, the write takes effect at once.
- R9: The two timers run independently. Each has its own settings and its own interrupt line, and traffic to one timer never alters the other.
- R10: The read data follows the address combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (5) | Byte address for both reads and writes |
| busWrEn | input | 1 | Write strobe |
| busUserMode | input | 1 | High when the write comes from user mode |
| busWrData | input | CNT_W (32) | Write data |
| busRdData | output | CNT_W (32) | Read data for busAddr |
| tmrIrq | output | N (2) | Interrupt pulse, one line per timer |
| protFault | output | 1 | Protection fault pulse |

## Verification
The assertions cover several rules on every cycle:
- A fault pulse follows each user-mode write, and only such writes.
- A user-mode write leaves the reload register as it was.
- An interrupt is raised only after an enabled counter stood at 1.
- A disabled counter holds unless it is written.

Other behaviours depend on a sequence of register traffic, and only the bench scenarios can show them:
- the rate at which each divisor code steps the counter;
- where single-shot and auto-reload counting end up;
- the deferred count write;
- address aliasing and misaligned accesses.

The bench runs a cycle model beside the block to check these.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Write strobes from the control section to one timer lane.
  typedef struct packed {
    logic reload;
    logic count;
    logic ctrl;
  } tmrStrobe_t;

  // Word offsets inside one timer's 16-byte window.
  localparam logic [1:0] OFF_RELOAD = 2'd0;
  localparam logic [1:0] OFF_COUNT  = 2'd1;
  localparam logic [1:0] OFF_CTRL   = 2'd2;

  localparam int RATE_W = 2;                 // width of the rate code
  localparam int NUM_RATES = 1 << RATE_W;    // divide by 1,2,4,8
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int NUM_RATES = 4,
  localparam int PRE_W = (NUM_RATES > 1) ? NUM_RATES - 1 : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [NUM_RATES-1:0] rateTick
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // Rate k fires when the low k bits are all ones.
  assign rateTick[0] = 1'b1;
  for (genvar k = 1; k < NUM_RATES; k++) begin : gRate
    assign rateTick[k] = &preCnt[k-1:0];
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int N = 2,
  parameter int CNT_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int ADDR_W = 4 + IDX_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic                       busUserMode,
  input  logic [N-1:0][CNT_W-1:0]    reloadArr,
  input  logic [N-1:0][CNT_W-1:0]    cntArr,
  input  logic [N-1:0][CNT_W-1:0]    ctrlArr,
  output tmrStrobe_t [N-1:0]         stb,
  output logic [CNT_W-1:0]           busRdData,
  output logic                       protFault
);
  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        off;
  logic              superWr;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign idx     = busAddr[ADDR_W-1:4];
  assign off     = busAddr[3:2];
  assign superWr = busWrEn && !busUserMode && aligned;

  for (genvar t = 0; t < N; t++) begin : gStb
    logic hit;
    assign hit = superWr && (idx == IDX_W'(t));
    assign stb[t].reload = hit && (off == OFF_RELOAD);
    assign stb[t].count  = hit && (off == OFF_COUNT);
    assign stb[t].ctrl   = hit && (off == OFF_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) protFault <= 1'b0;
    else       protFault <= busWrEn && busUserMode;
  end

  always_comb begin
    busRdData = '0;
    if (aligned && (int'(idx) < N)) begin
      case (off)
        OFF_RELOAD: busRdData = reloadArr[idx];
        OFF_COUNT:  busRdData = cntArr[idx];
        OFF_CTRL:   busRdData = ctrlArr[idx];
        default:    busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int N = 2,
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tmrStrobe_t [N-1:0]       stb,
  input  logic [CNT_W-1:0]         wrData,
  input  logic [NUM_RATES-1:0]     rateTick,
  output logic [N-1:0][CNT_W-1:0]  reloadArr,
  output logic [N-1:0][CNT_W-1:0]  cntArr,
  output logic [N-1:0][CNT_W-1:0]  ctrlArr,
  output logic [N-1:0]             enArr,
  output logic [N-1:0]             autoArr,
  output logic [N-1:0]             irq
);
  for (genvar t = 0; t < N; t++) begin : gLane
    logic [CNT_W-1:0]  reloadQ, cntQ, pendVal;
    logic              enQ, autoQ, pendQ, irqQ;
    logic [RATE_W-1:0] rateQ;
    logic              step;

    assign step = enQ && rateTick[rateQ];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reloadQ <= '0; cntQ <= '0; pendVal <= '0;
        enQ <= 1'b0; autoQ <= 1'b0; pendQ <= 1'b0; irqQ <= 1'b0;
        rateQ <= '0;
      end else begin
        irqQ <= 1'b0;
        if (step) begin
          if (pendQ) begin
            cntQ  <= pendVal;
            pendQ <= 1'b0;
          end else if (cntQ == CNT_W'(1)) begin
            irqQ <= 1'b1;
            if (autoQ) cntQ <= reloadQ;
            else begin
              cntQ <= '0;
              enQ  <= 1'b0;
            end
          end else if (cntQ == '0) begin
            if (autoQ) cntQ <= reloadQ;
            else       enQ  <= 1'b0;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        // Register writes override the step's effect on the same field.
        if (stb[t].reload) reloadQ <= wrData;
        if (stb[t].count) begin
          if (enQ) begin
            pendQ   <= 1'b1;
            pendVal <= wrData;
          end else begin
            cntQ  <= wrData;
            pendQ <= 1'b0;
          end
        end
        if (stb[t].ctrl) begin
          enQ   <= wrData[0];
          autoQ <= wrData[1];
          rateQ <= wrData[2 +: RATE_W];
        end
      end
    end

    assign reloadArr[t] = reloadQ;
    assign cntArr[t]    = cntQ;
    assign ctrlArr[t]   = CNT_W'({rateQ, autoQ, enQ});
    assign enArr[t]     = enQ;
    assign autoArr[t]   = autoQ;
    assign irq[t]       = irqQ;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int N = 2,
  parameter int CNT_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int ADDR_W = 4 + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busUserMode,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic [N-1:0]      tmrIrq,
  output logic              protFault
);
  tmrStrobe_t [N-1:0]        stb;
  logic [NUM_RATES-1:0]      rateTick;
  logic [N-1:0][CNT_W-1:0]   reloadArr, cntArr, ctrlArr;
  logic [N-1:0]              enArr, autoArr;

  timer_prescaler #(.NUM_RATES(NUM_RATES)) uPre (
    .clk(clk), .rstN(rstN), .rateTick(rateTick)
  );

  timer_ctrl #(.N(N), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busUserMode(busUserMode), .reloadArr(reloadArr), .cntArr(cntArr),
    .ctrlArr(ctrlArr), .stb(stb), .busRdData(busRdData), .protFault(protFault)
  );

  timer_datapath #(.N(N), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .rateTick(rateTick),
    .reloadArr(reloadArr), .cntArr(cntArr), .ctrlArr(ctrlArr),
    .enArr(enArr), .autoArr(autoArr), .irq(tmrIrq)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int N = 2,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     busWrEn,
  input logic                     busUserMode,
  input logic [CNT_W-1:0]         busRdData,
  input logic [N-1:0]             tmrIrq,
  input logic                     protFault,
  input tmrStrobe_t [N-1:0]       stb,
  input logic [N-1:0][CNT_W-1:0]  cntArr,
  input logic [N-1:0]             enArr
);
  a_r7_fault_after_user_write: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busUserMode |=> protFault);

  a_r7_no_spurious_fault: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busUserMode) |=> !protFault);

  a_r7_user_write_keeps_reload: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busUserMode && (busAddr[3:0] == 4'd0)
      |=> ($stable(busAddr) -> $stable(busRdData)));

  for (genvar t = 0; t < N; t++) begin : gLaneChk
    a_r4_irq_from_one: assert property (@(posedge clk) disable iff (!rstN)
      tmrIrq[t] |-> ($past(cntArr[t]) == CNT_W'(1)) && $past(enArr[t]));

    a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
      !enArr[t] && !stb[t].count |=> $stable(cntArr[t]));
  end
endmodule

bind dual_interval_timer timer_checker #(.N(N), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busUserMode(busUserMode), .busRdData(busRdData), .tmrIrq(tmrIrq),
  .protFault(protFault), .stb(stb), .cntArr(cntArr), .enArr(enArr)
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;
  localparam int N = 2;
  localparam int CNT_W = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busUserMode = 1'b0;
  logic [CNT_W-1:0]  busWrData = '0;
  logic [CNT_W-1:0]  busRdData;
  logic [N-1:0]      tmrIrq;
  logic              protFault;

  always #2.5 clk = ~clk;

  dual_interval_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busUserMode(busUserMode), .busWrData(busWrData), .busRdData(busRdData),
    .tmrIrq(tmrIrq), .protFault(protFault)
  );

  int nChk = 0;
  int nFail = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  string curTag = "R1";

  // Reference model built from the requirements.
  logic [CNT_W-1:0] mReload [N];
  logic [CNT_W-1:0] mCnt [N];
  logic [CNT_W-1:0] mPendVal [N];
  logic             mEn [N], mAuto [N], mPend [N], mIrq [N];
  logic [1:0]       mRate [N];
  logic [2:0]       mPre;
  logic             mFault;

  function automatic logic [CNT_W-1:0] mRead(logic [ADDR_W-1:0] a);
    int t;
    t = int'(a[4]);
    if (a[1:0] != 2'b00) return '0;
    case (a[3:2])
      2'd0: return mReload[t];
      2'd1: return mCnt[t];
      2'd2: return CNT_W'({mRate[t], mAuto[t], mEn[t]});
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < N; t++) begin
        mReload[t] = '0; mCnt[t] = '0; mPendVal[t] = '0;
        mEn[t] = 0; mAuto[t] = 0; mPend[t] = 0; mIrq[t] = 0; mRate[t] = '0;
      end
      mPre = '0; mFault = 0;
    end else begin
      for (int t = 0; t < N; t++) begin
        logic [2:0] msk;
        logic oldEn;
        msk = 3'((1 << mRate[t]) - 1);
        oldEn = mEn[t];
        mIrq[t] = 0;
        if (mEn[t] && ((mPre & msk) == msk)) begin
          if (mPend[t]) begin mCnt[t] = mPendVal[t]; mPend[t] = 0; end
          else if (mCnt[t] == 1) begin
            mIrq[t] = 1;
            if (mAuto[t]) mCnt[t] = mReload[t];
            else begin mCnt[t] = 0; mEn[t] = 0; end
          end else if (mCnt[t] == 0) begin
            if (mAuto[t]) mCnt[t] = mReload[t]; else mEn[t] = 0;
          end else mCnt[t] = mCnt[t] - 1;
        end
        if (busWrEn && !busUserMode && busAddr[1:0] == 2'b00 && int'(busAddr[4]) == t) begin
          case (busAddr[3:2])
            2'd0: mReload[t] = busWrData;
            2'd1: if (oldEn) begin mPend[t] = 1; mPendVal[t] = busWrData; end
                  else begin mCnt[t] = busWrData; mPend[t] = 0; end
            2'd2: begin mEn[t] = busWrData[0]; mAuto[t] = busWrData[1]; mRate[t] = busWrData[3:2]; end
            default: ;
          endcase
        end
      end
      mFault = busWrEn && busUserMode;
      mPre = mPre + 1;
    end
  end

  task automatic chk(string tag, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Cycle monitor, sampled 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (monOn) begin
      for (int t = 0; t < N; t++)
        chk($sformatf("%s irq%0d (R4)", curTag, t), CNT_W'(tmrIrq[t]), CNT_W'(mIrq[t]));
      chk($sformatf("%s fault (R7)", curTag), CNT_W'(protFault), CNT_W'(mFault));
      chk($sformatf("%s rdData (R10)", curTag), busRdData, mRead(busAddr));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [CNT_W-1:0] d, logic user);
    @(negedge clk);
    busAddr = a; busWrData = d; busUserMode = user; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busUserMode = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [ADDR_W-1:0] a, logic [CNT_W-1:0] exp);
    @(negedge clk);
    busAddr = a;
    #0.5;
    chk(tag, busRdData, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(4);
    rstN = 1'b1;
    // R1: reset values
    for (int a = 0; a < 32; a += 4) rdChk("R1 reset register", ADDR_W'(a), '0);
    chk("R1 irq at reset", CNT_W'(tmrIrq), '0);
    chk("R1 fault at reset", CNT_W'(protFault), '0);
    monOn = 1'b1;

    // R2: map and misaligned access
    curTag = "R2";
    wr(5'd16, 32'h1234_5678, 1'b0);
    wr(5'd17, 32'h0000_FFFF, 1'b0);
    wr(5'd12, 32'h0000_00FF, 1'b0);
    rdChk("R2 reload of timer1", 5'd16, 32'h1234_5678);
    rdChk("R2 misaligned read", 5'd17, '0);
    rdChk("R2 spare offset", 5'd12, '0);
    rdChk("R2 timer0 reload untouched", 5'd0, '0);

    // R10: combinational read
    curTag = "R10";
    @(negedge clk); busAddr = 5'd16; #0.5;
    chk("R10 same-cycle read", busRdData, 32'h1234_5678);
    busAddr = 5'd0; #0.5;
    chk("R10 same-cycle read", busRdData, 32'h0);

    // R5: single-shot
    curTag = "R5";
    wr(5'd4, 32'd3, 1'b0);
    wr(5'd8, 32'h1, 1'b0);
    idle(8);
    rdChk("R5 enable cleared", 5'd8, 32'h0);
    rdChk("R5 count at zero", 5'd4, 32'h0);
    wr(5'd8, 32'h1, 1'b0);
    idle(4);
    rdChk("R5 start at zero stops", 5'd8, 32'h0);

    // R4: decrement at divide-by-2
    curTag = "R4";
    wr(5'd4, 32'd6, 1'b0);
    wr(5'd8, 32'h5, 1'b0);
    idle(20);
    rdChk("R4 count after run", 5'd4, 32'h0);

    // R6: auto-reload
    curTag = "R6";
    wr(5'd0, 32'd4, 1'b0);
    wr(5'd4, 32'd2, 1'b0);
    wr(5'd8, 32'h3, 1'b0);
    idle(20);
    rdChk("R6 stays enabled", 5'd8, 32'h3);

    // R3: slowest rate on timer1, then disable and hold
    curTag = "R3";
    wr(5'd16, 32'd3, 1'b0);
    wr(5'd20, 32'd5, 1'b0);
    wr(5'd24, 32'hD, 1'b0);
    idle(60);
    wr(5'd24, 32'h0, 1'b0);
    rdChk("R3 count readable", 5'd20, mRead(5'd20));
    begin
      logic [CNT_W-1:0] held;
      held = busRdData;
      idle(12);
      rdChk("R3 disabled holds", 5'd20, held);
    end

    // R8: deferred count write
    curTag = "R8";
    wr(5'd8, 32'h0, 1'b0);
    wr(5'd0, 32'd9, 1'b0);
    wr(5'd4, 32'd9, 1'b0);
    wr(5'd8, 32'hF, 1'b0);
    idle(3);
    wr(5'd4, 32'd2, 1'b0);
    rdChk("R8 count read after write", 5'd4, mRead(5'd4));
    idle(20);
    rdChk("R8 count settled", 5'd4, mRead(5'd4));

    // R7: user-mode writes
    curTag = "R7";
    wr(5'd0, 32'hAAAA, 1'b1);
    rdChk("R7 reload unchanged", 5'd0, 32'd9);
    wr(5'd8, 32'h0, 1'b1);
    rdChk("R7 control unchanged", 5'd8, 32'hF);

    // R9: random traffic over both timers
    curTag = "R9";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      busAddr = {1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00};
      busWrEn = ($urandom_range(0, 9) < 3);
      busUserMode = ($urandom_range(0, 4) == 0);
      busWrData = (busAddr[3:2] == 2'd2) ? 32'($urandom_range(0, 15))
                                         : 32'($urandom_range(0, 12));
    end
    @(negedge clk);
    busWrEn = 1'b0;
    idle(3);
    for (int a = 0; a < 32; a += 4) rdChk("R9 final state", ADDR_W'(a), mRead(ADDR_W'(a)));

    monOn = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule